// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the transfer engine of a single DMA channel. Software loads a source pointer, a destination pointer, a 24-bit unit count and a 16-bit control word through a one-cycle configuration strobe. A start pulse then launches the channel. For each unit the engine issues one read request at the source pointer and waits for the returned data. It then issues one write request carrying that data at the destination pointer. After the write is accepted, it steps both pointers and decrements the count.

The control word sets the unit size, an independent step mode for each pointer, and whether each side is memory or a device. It also holds the enable and transfer-end flags. An optional run limit caps the number of units per launch, so a channel can be advanced in slices. When the count runs out, the transfer-end flag is set and a one-cycle done pulse is raised. Pointers and the count always reflect the progress made, so a partial run can be resumed. A launch with a pointer that is not aligned to the unit size is refused. In that case an address-error flag is raised and no requests are made.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `addrErr` and `reqValid` are 0, and the configuration registers read 0.
- R2: Each unit is a read request at `srcReg`, followed by a write request at `dstReg`. The write request's `reqWdata` equals the `rdData` returned for that read, and the next unit's read comes only after the write is accepted.
- R3: The unit size comes from control bits [6:4]: code 0 gives 8 bytes, 1 gives 1, 2 gives 2, 3 gives 4, 4 gives 32, and codes 5, 6 and 7 give 1 byte. `reqBytes` carries this size.
- R4: After each accepted write, the source pointer steps by mode bits [13:12] and the destination pointer by bits [15:14]. Mode 0 holds the pointer, 1 adds the unit size, 2 subtracts it, and 3 holds it.
- R5: `reqDev` is control bit 9 on read requests and control bit 8 on write requests. These are bits 1 and 0 of the resource field [11:8].
- R6: `cntReg` decrements by one per completed unit, with 24-bit wrap. A loaded count of 0 stands for 2^24 units, so two units from a count of 0 leave 0xFFFFFE.
- R7: When the count reaches 0, control bit 1 (transfer end) is set. `done` pulses for one cycle, `busy` falls and no further request is issued.
- R8: A `runLimit` of 0 runs until the count is exhausted. A nonzero limit stops the channel after that many units, with `done` pulsing and the transfer-end flag left clear. A limit above the remaining count ends at the count. `unitsDone` reports the units of the latest launch.
- R9: A start is ignored, with no request and `busy` staying 0, unless control bit 0 (enable) is 1 and bit 1 (transfer end) is 0.
- R10: A start with either pointer not a multiple of the unit size sets `addrErr` and issues no request. A later configuration write clears `addrErr`.
- R11: While `reqValid` is high and `reqReady` low, the request holds `reqValid`, `reqWrite` and `reqAddr` unchanged into the next cycle.
- R12: A configuration write while `busy` is high has no effect on the registers or the running transfer.
- R13: `reqBurst` is high exactly for 32-byte units, and such a request's address is 32-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Load the four configuration values (idle only) |
| cfgSrc | input | ADDR_W | Source pointer to load |
| cfgDst | input | ADDR_W | Destination pointer to load |
| cfgCnt | input | CNT_W | Unit count to load (0 means 2^CNT_W) |
| cfgCtl | input | 16 | Control word to load |
| start | input | 1 | Launch pulse |
| runLimit | input | CNT_W | Units per launch, 0 for unlimited |
| reqValid | output | 1 | Memory request valid |
| reqReady | input | 1 | Memory request accepted |
| reqWrite | output | 1 | 1 for write request, 0 for read |
| reqDev | output | 1 | Request targets a device rather than memory |
| reqBurst | output | 1 | Request is a 32-byte burst |
| reqBytes | output | 6 | Unit size in bytes |
| reqAddr | output | ADDR_W | Request address |
| reqWdata | output | DATA_W | Write data |
| rdValid | input | 1 | Read data return strobe |
| rdData | input | DATA_W | Read data |
| srcReg | output | ADDR_W | Current source pointer |
| dstReg | output | ADDR_W | Current destination pointer |
| cntReg | output | CNT_W | Current remaining count |
| ctlReg | output | 16 | Current control word, including transfer-end flag |
| unitsDone | output | CNT_W+1 | Units completed since the last launch |
| busy | output | 1 | Channel running |
| done | output | 1 | One-cycle pulse when a run stops |
| addrErr | output | 1 | Misaligned launch was refused |

## Verification
The assertions assume a well-behaved memory side. `rdValid` arrives exactly once, only after a read request is accepted. The configuration strobe and the start pulse are never raised in the same cycle. The bench memory model answers each accepted read one cycle later with address-derived data. Its `reqReady` follows a repeating pattern with stall cycles, so request holding is exercised without breaking these rules. The bench drives configuration and start only on separate falling edges.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int CTL_W = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RD,
    SEQ_RDW,
    SEQ_WR
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // take configuration values
    logic launch;   // start a run
    logic fault;    // refused misaligned launch
    logic grabRd;   // capture returned read data
    logic advance;  // write accepted: step pointers and count
  } seqStrobeT;

  function automatic logic [5:0] unitBytes(input logic [2:0] code);
    case (code)
      3'd0:    unitBytes = 6'd8;
      3'd2:    unitBytes = 6'd2;
      3'd3:    unitBytes = 6'd4;
      3'd4:    unitBytes = 6'd32;
      default: unitBytes = 6'd1;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWr,
  input  logic      start,
  input  logic      runnable,
  input  logic      aligned,
  input  logic      lastUnit,
  input  logic      reqReady,
  input  logic      rdValid,
  output seqStrobeT stb,
  output logic      reqValid,
  output logic      reqWrite,
  output logic      busy,
  output logic      done
);

  seqStateT stateQ, stateD;
  logic     doneQ, doneD;

  always_comb begin
    stateD = stateQ;
    doneD  = 1'b0;
    stb    = '0;
    case (stateQ)
      SEQ_IDLE: begin
        stb.load = cfgWr;
        if (start && runnable) begin
          if (aligned) begin
            stb.launch = 1'b1;
            stateD     = SEQ_RD;
          end else begin
            stb.fault = 1'b1;
          end
        end
      end
      SEQ_RD: begin
        if (reqReady) stateD = SEQ_RDW;
      end
      SEQ_RDW: begin
        if (rdValid) begin
          stb.grabRd = 1'b1;
          stateD     = SEQ_WR;
        end
      end
      SEQ_WR: begin
        if (reqReady) begin
          stb.advance = 1'b1;
          if (lastUnit) begin
            doneD  = 1'b1;
            stateD = SEQ_IDLE;
          end else begin
            stateD = SEQ_RD;
          end
        end
      end
      default: stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
    end
  end

  assign reqValid = (stateQ == SEQ_RD) || (stateQ == SEQ_WR);
  assign reqWrite = (stateQ == SEQ_WR);
  assign busy     = (stateQ != SEQ_IDLE);
  assign done     = doneQ;

endmodule

// File: rtl/dma_chan_path.sv
module dma_chan_path
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         stb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgCnt,
  input  logic [CTL_W-1:0]  cfgCtl,
  input  logic [CNT_W-1:0]  runLimit,
  input  logic [DATA_W-1:0] rdData,
  output logic              runnable,
  output logic              aligned,
  output logic              lastUnit,
  output logic              reqDev,
  output logic              reqBurst,
  output logic [5:0]        reqBytes,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] srcReg,
  output logic [ADDR_W-1:0] dstReg,
  output logic [CNT_W-1:0]  cntReg,
  output logic [CTL_W-1:0]  ctlReg,
  output logic [CNT_W:0]    unitsDone,
  output logic              addrErr
);

  localparam int NPTR = 2;  // index 0 source, 1 destination

  logic [CTL_W-1:0]  ctlQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  runLeftQ;
  logic              limOnQ;
  logic [CNT_W:0]    unitsQ;
  logic [DATA_W-1:0] bufQ;
  logic              errQ;
  logic [5:0]        bytes;
  logic [NPTR-1:0]   ptrOk;
  logic [ADDR_W-1:0] ptrCur [NPTR];

  assign bytes = unitBytes(ctlQ[6:4]);

  for (genvar p = 0; p < NPTR; p++) begin : gPtr
    logic [ADDR_W-1:0] ptrQ;
    logic [ADDR_W-1:0] ptrNext;
    logic [ADDR_W-1:0] ptrLoad;
    logic [1:0]        mode;

    assign mode    = (p == 0) ? ctlQ[13:12] : ctlQ[15:14];
    assign ptrLoad = (p == 0) ? cfgSrc : cfgDst;

    always_comb begin
      case (mode)
        2'd1:    ptrNext = ptrQ + ADDR_W'(bytes);
        2'd2:    ptrNext = ptrQ - ADDR_W'(bytes);
        default: ptrNext = ptrQ;
      endcase
    end

    assign ptrOk[p]  = ((ptrQ & ADDR_W'(bytes - 6'd1)) == '0);
    assign ptrCur[p] = ptrQ;

    always_ff @(posedge clk) begin
      if (!rstN)            ptrQ <= '0;
      else if (stb.load)    ptrQ <= ptrLoad;
      else if (stb.advance) ptrQ <= ptrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ     <= '0;
      cntQ     <= '0;
      runLeftQ <= '0;
      limOnQ   <= 1'b0;
      unitsQ   <= '0;
      bufQ     <= '0;
      errQ     <= 1'b0;
    end else begin
      if (stb.load) begin
        ctlQ <= cfgCtl;
        cntQ <= cfgCnt;
        errQ <= 1'b0;
      end
      if (stb.fault) errQ <= 1'b1;
      if (stb.launch) begin
        unitsQ   <= '0;
        runLeftQ <= runLimit;
        limOnQ   <= (runLimit != '0);
      end
      if (stb.grabRd) bufQ <= rdData;
      if (stb.advance) begin
        cntQ     <= cntQ - CNT_W'(1);
        runLeftQ <= runLeftQ - CNT_W'(1);
        unitsQ   <= unitsQ + (CNT_W+1)'(1);
        if (cntQ == CNT_W'(1)) ctlQ[1] <= 1'b1;
      end
    end
  end

  assign runnable  = ctlQ[0] & ~ctlQ[1];
  assign aligned   = &ptrOk;
  assign lastUnit  = (cntQ == CNT_W'(1)) || (limOnQ && (runLeftQ == CNT_W'(1)));

  assign reqAddr   = reqWrite ? ptrCur[1] : ptrCur[0];
  assign reqDev    = reqWrite ? ctlQ[8] : ctlQ[9];
  assign reqBytes  = bytes;
  assign reqBurst  = (bytes == 6'd32);
  assign reqWdata  = bufQ;

  assign srcReg    = ptrCur[0];
  assign dstReg    = ptrCur[1];
  assign cntReg    = cntQ;
  assign ctlReg    = ctlQ;
  assign unitsDone = unitsQ;
  assign addrErr   = errQ;

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgCnt,
  input  logic [15:0]       cfgCtl,
  input  logic              start,
  input  logic [CNT_W-1:0]  runLimit,
  output logic              reqValid,
  input  logic              reqReady,
  output logic              reqWrite,
  output logic              reqDev,
  output logic              reqBurst,
  output logic [5:0]        reqBytes,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] srcReg,
  output logic [ADDR_W-1:0] dstReg,
  output logic [CNT_W-1:0]  cntReg,
  output logic [15:0]       ctlReg,
  output logic [CNT_W:0]    unitsDone,
  output logic              busy,
  output logic              done,
  output logic              addrErr
);

  seqStrobeT stb;
  logic      runnable;
  logic      aligned;
  logic      lastUnit;

  dma_chan_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWr    (cfgWr),
    .start    (start),
    .runnable (runnable),
    .aligned  (aligned),
    .lastUnit (lastUnit),
    .reqReady (reqReady),
    .rdValid  (rdValid),
    .stb      (stb),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .busy     (busy),
    .done     (done)
  );

  dma_chan_path #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqWrite  (reqWrite),
    .cfgSrc    (cfgSrc),
    .cfgDst    (cfgDst),
    .cfgCnt    (cfgCnt),
    .cfgCtl    (cfgCtl),
    .runLimit  (runLimit),
    .rdData    (rdData),
    .runnable  (runnable),
    .aligned   (aligned),
    .lastUnit  (lastUnit),
    .reqDev    (reqDev),
    .reqBurst  (reqBurst),
    .reqBytes  (reqBytes),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .srcReg    (srcReg),
    .dstReg    (dstReg),
    .cntReg    (cntReg),
    .ctlReg    (ctlReg),
    .unitsDone (unitsDone),
    .addrErr   (addrErr)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWr,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic              reqBurst,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [CNT_W-1:0]  cntReg,
  input logic [15:0]       ctlReg,
  input logic              busy,
  input logic              done,
  input logic              addrErr
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqWrite) && $stable(reqAddr)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid);

  // R7
  te_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctlReg[1]) && !$past(cfgWr)) |-> (done && !busy));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqReady) |=> (cntReg == $past(cntReg) - CNT_W'(1)));

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> !busy);

  // R13
  burst_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqBurst) |-> (reqAddr[4:0] == 5'd0));

endmodule

bind dma_chan_seq dma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;

  localparam int AW = 32;
  localparam int CW = 24;
  localparam int DW = 256;

  typedef struct {
    logic [AW-1:0] addr;
    logic          wr;
    logic          dev;
    logic [5:0]    bytes;
    logic [DW-1:0] data;
  } expT;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWr = 1'b0;
  logic [AW-1:0] cfgSrc = '0;
  logic [AW-1:0] cfgDst = '0;
  logic [CW-1:0] cfgCnt = '0;
  logic [15:0]   cfgCtl = '0;
  logic          start = 1'b0;
  logic [CW-1:0] runLimit = '0;
  logic          reqValid, reqWrite, reqDev, reqBurst;
  logic          reqReady = 1'b0;
  logic [5:0]    reqBytes;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqWdata;
  logic          rdValid = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic [AW-1:0] srcReg, dstReg;
  logic [CW-1:0] cntReg;
  logic [15:0]   ctlReg;
  logic [CW:0]   unitsDone;
  logic          busy, done, addrErr;

  int   nChk = 0;
  int   nBad = 0;
  int   cyc  = 0;
  expT  q[$];

  always #10 clk = ~clk;

  dma_chan_seq u0 (.*);

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {8{a ^ 32'h5A5A_0F0F}};
  endfunction

  // R3 size table
  function automatic logic [5:0] szOf(input logic [2:0] c);
    case (c)
      3'd0: return 6'd8;
      3'd1: return 6'd1;
      3'd2: return 6'd2;
      3'd3: return 6'd4;
      3'd4: return 6'd32;
      default: return 6'd1;
    endcase
  endfunction

  // R4 step table
  function automatic logic [AW-1:0] stepOf(input logic [1:0] m, input logic [AW-1:0] p,
                                           input logic [5:0] b);
    case (m)
      2'd1: return p + AW'(b);
      2'd2: return p - AW'(b);
      default: return p;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: ready pattern with stalls, read data one cycle after accept
  always @(posedge clk) begin
    cyc      <= cyc + 1;
    reqReady <= (cyc % 3) != 1;
    rdValid  <= reqValid && reqReady && !reqWrite;
    rdData   <= pat(reqAddr);
  end

  // monitor: compare every accepted request with the scoreboard
  always @(negedge clk) begin
    if (rstN && reqValid && reqReady) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9/R10 unexpected request", 64'(reqAddr), 64'(0));
      end else begin
        expT e;
        e = q.pop_front();
        chk(reqAddr == e.addr, "R2/R4 address", 64'(reqAddr), 64'(e.addr));
        chk(reqWrite == e.wr, "R2 order", 64'(reqWrite), 64'(e.wr));
        chk(reqDev == e.dev, "R5 device flag", 64'(reqDev), 64'(e.dev));
        chk(reqBytes == e.bytes, "R3 unit size", 64'(reqBytes), 64'(e.bytes));
        chk(reqBurst == (e.bytes == 6'd32), "R13 burst flag", 64'(reqBurst),
            64'(e.bytes == 6'd32));
        if (e.wr) chk(reqWdata == e.data, "R2 write data", reqWdata[63:0], e.data[63:0]);
      end
    end
  end

  task automatic doCfg(input logic [AW-1:0] s, d, input logic [CW-1:0] c,
                       input logic [15:0] k);
    @(negedge clk);
    cfgWr = 1'b1; cfgSrc = s; cfgDst = d; cfgCnt = c; cfgCtl = k;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic doStart(input logic [CW-1:0] lim);
    @(negedge clk);
    start = 1'b1; runLimit = lim;
    @(negedge clk);
    start = 1'b0;
  endtask

  // driver: predicts the request stream, runs the job, checks the final state
  task automatic runJob(input logic [AW-1:0] s, d, input logic [CW-1:0] c,
                        input logic [15:0] k, input logic [CW-1:0] lim,
                        input logic load, input logic poke, input string tag);
    logic [5:0]    b;
    logic [AW-1:0] sp, dp;
    logic [CW:0]   eff, n;
    logic          sawDone;
    b   = szOf(k[6:4]);
    sp  = s;
    dp  = d;
    eff = (c == '0) ? (CW+1)'(1) << CW : {1'b0, c};
    n   = (lim == '0 || {1'b0, lim} > eff) ? eff : {1'b0, lim};
    for (int i = 0; i < int'(n); i++) begin
      q.push_back('{addr: sp, wr: 1'b0, dev: k[9], bytes: b, data: '0});
      q.push_back('{addr: dp, wr: 1'b1, dev: k[8], bytes: b, data: pat(sp)});
      sp = stepOf(k[13:12], sp, b);
      dp = stepOf(k[15:14], dp, b);
    end
    if (load) doCfg(s, d, c, k);
    doStart(lim);
    if (poke) begin
      repeat (2) @(negedge clk);
      cfgWr = 1'b1; cfgSrc = 32'hDEAD_0000; cfgDst = 32'hBEEF_0000;
      cfgCnt = 24'h77; cfgCtl = 16'h0;
      @(negedge clk);
      cfgWr = 1'b0;
    end
    sawDone = 1'b0;
    for (int t = 0; t < 4000 && !sawDone; t++) begin
      if (done) sawDone = 1'b1;
      else @(negedge clk);
    end
    chk(sawDone, {tag, " R7/R8 done pulse"}, 64'(sawDone), 64'(1));
    chk(!busy, {tag, " R7 busy low at done"}, 64'(busy), 64'(0));
    @(negedge clk);
    chk(!done, {tag, " R7 done one cycle"}, 64'(done), 64'(0));
    chk(q.size() == 0, {tag, " R2 all requests seen"}, 64'(q.size()), 64'(0));
    q.delete();
    chk(srcReg == sp, {tag, " R4 source pointer"}, 64'(srcReg), 64'(sp));
    chk(dstReg == dp, {tag, " R4 destination pointer"}, 64'(dstReg), 64'(dp));
    chk(cntReg == CW'(c - CW'(n)), {tag, " R6 count"}, 64'(cntReg), 64'(CW'(c - CW'(n))));
    chk(ctlReg[1] == (n == eff), {tag, " R7/R8 end flag"}, 64'(ctlReg[1]), 64'(n == eff));
    chk(unitsDone == n, {tag, " R8 units done"}, 64'(unitsDone), 64'(n));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'(0));
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !addrErr && !reqValid, "R1 idle after reset",
        {busy, done, addrErr, reqValid}, 64'(0));
    chk(srcReg == '0 && cntReg == '0 && ctlReg == '0, "R1 registers zero",
        64'(cntReg), 64'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // inc/inc, 4-byte units, memory to memory
    runJob(32'h0000_1000, 32'h0000_2000, 24'd3, 16'h5031, 24'd0, 1, 0, "incinc");
    // fixed source from device, decrementing destination, 1-byte units
    runJob(32'h0000_3003, 32'h0000_4007, 24'd2, 16'h8211, 24'd0, 1, 0, "devsrc");
    // 8-byte units, source inc, destination reserved mode (holds), device sink
    runJob(32'h0000_5000, 32'h0000_6008, 24'd2, 16'hD101, 24'd0, 1, 0, "reserved");
    // 32-byte bursts
    runJob(32'h0000_7020, 32'h0000_8040, 24'd2, 16'h5041, 24'd0, 1, 0, "burst");
    // size codes 5..7 behave as 1 byte
    runJob(32'h0000_9001, 32'h0000_A003, 24'd2, 16'h5051, 24'd0, 1, 0, "code5");
    runJob(32'h0000_9001, 32'h0000_A003, 24'd1, 16'h5071, 24'd0, 1, 0, "code7");
    // R8 run limit then resume with an oversize limit
    runJob(32'h0000_B000, 32'h0000_C000, 24'd5, 16'h5021, 24'd2, 1, 0, "limA");
    runJob(32'h0000_B004, 32'h0000_C004, 24'd3, 16'h5021, 24'd10, 0, 0, "limB");
    // R6 count 0 means 2^24: two units leave 0xFFFFFE
    runJob(32'h0000_D000, 32'h0000_E000, 24'd0, 16'h5031, 24'd2, 1, 0, "zerocnt");
    // R12 configuration write during a run
    runJob(32'h0001_0000, 32'h0002_0000, 24'd4, 16'h5031, 24'd0, 1, 1, "busycfg");

    // R9 start with transfer-end already set (left by previous job)
    doStart(24'd0);
    chk(!busy && !reqValid, "R9 start ignored with end flag", 64'(busy), 64'(0));
    // R9 start with enable clear
    doCfg(32'h100, 32'h200, 24'd3, 16'h5030);
    doStart(24'd0);
    chk(!busy && !reqValid, "R9 start ignored with enable clear", 64'(busy), 64'(0));
    chk(cntReg == 24'd3, "R9 count untouched", 64'(cntReg), 64'(3));

    // R10 misaligned burst
    doCfg(32'h0000_0021, 32'h0000_0040, 24'd2, 16'h5041);
    doStart(24'd0);
    chk(addrErr, "R10 address error raised", 64'(addrErr), 64'(1));
    chk(!busy, "R10 no launch", 64'(busy), 64'(0));
    repeat (3) @(negedge clk);
    chk(cntReg == 24'd2 && srcReg == 32'h21, "R10 state untouched", 64'(cntReg), 64'(2));
    doCfg(32'h0000_0020, 32'h0000_0040, 24'd1, 16'h5041);
    chk(!addrErr, "R10 cleared by configuration", 64'(addrErr), 64'(0));
    // misaligned 4-byte destination
    doCfg(32'h0000_0100, 32'h0000_0202, 24'd1, 16'h5031);
    doStart(24'd0);
    chk(addrErr, "R10 misaligned destination", 64'(addrErr), 64'(1));

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule